// File: doc/BRIEF.md
# Complementary Output Short Detector

This block watches the three complementary output pairs of a motor-control PWM timer and raises a sticky fault flag when both legs of any one pair are at their active level together, a condition that would short the supply through a half-bridge. Each of the six outputs has its own polarity input that says whether that leg is active high or active low. The pair count is a parameter.

The block carries one 16-bit control and status register. It holds a comparison enable, an interrupt enable and the fault flag. Software clears the flag with a two-step handshake: it must first read the register while the flag is 1, then write the flag bit as 0. The comparison enable may be written only once after reset. While the flag is set, the block drives an output-disable request so that the pins can be forced to a safe state elsewhere. It also raises an interrupt request when the interrupt enable allows it.

Top module: `cmp_short_detector`

## Requirements
- R1: After reset, every register bit is 0, and `short_flag`, `irq` and `out_disable` are low.
- R2: A pair p is active in a cycle when `pwm_level[2p]==act_high[2p]` and `pwm_level[2p+1]==act_high[2p+1]`. A polarity bit of 1 means active high and 0 means active low. If the comparison enable is 1 and any pair is active at a clock edge, `short_flag` is 1 from that edge on.
- R3: While the comparison enable is 0, an active pair never sets the flag.
- R4: The flag is sticky. It stays 1 after every pair has returned to an inactive state.
- R5: The flag clears at a clock edge only when a register write carries bit 15 = 0 and an earlier read (`reg_rd`) saw the flag as 1 with no write in between. A write of 0 without such a read leaves the flag set. Any write consumes the read.
- R6: A write with bit 15 = 1 never changes the flag. If a set condition and a valid clearing write occur in the same cycle, the flag stays 1.
- R7: The comparison enable (bit 9) is loaded by the first register write after reset. Later writes leave it unchanged.
- R8: The interrupt enable (bit 8) is loaded by every register write. `irq` is high exactly when the flag and the interrupt enable are both 1.
- R9: `out_disable` is high exactly when the flag is 1.
- R10: `reg_rdata` shows the flag in bit 15, the comparison enable in bit 9 and the interrupt enable in bit 8. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pwm_level | input | 6 | Observed levels of the six outputs; pair p is bits 2p and 2p+1 |
| act_high | input | 6 | Per-output active polarity, 1 = active high |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| short_flag | output | 1 | Sticky short-circuit flag |
| irq | output | 1 | Interrupt request |
| out_disable | output | 1 | Output-disable request |

## Verification
Several input patterns are applied:
- Complementary patterns with every leg active high, which must never trip the flag. This separates a pair check from a plain level check.
- The same overlap applied to each pair in turn, which exposes a missing or miswired pair.
- Overlaps with mixed polarity, including legs that are active low, which show whether each output's own polarity bit is honoured.
- The clearing handshake, run with the read missing, with a flag-1 write, with a stray write in between, and together with a new overlap. These runs separate the read-then-clear protocol from a plain write-to-clear.

// File: rtl/cmp_short_detector.sv
module cmp_short_detector #(
  parameter int NPAIRS = 3,
  parameter int RW     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NPAIRS-1:0] pwm_level,
  input  logic [2*NPAIRS-1:0] act_high,
  input  logic                reg_rd,
  input  logic                reg_wr,
  input  logic [RW-1:0]       reg_wdata,
  output logic [RW-1:0]       reg_rdata,
  output logic                short_flag,
  output logic                irq,
  output logic                out_disable
);
  localparam int FLAG_BIT = RW - 1;
  localparam int EN_BIT   = 9;
  localparam int IE_BIT   = 8;

  logic [NPAIRS-1:0] pair_hit;
  logic flag_q, en_q, ie_q, locked_q, armed_q;
  logic set_c, clr_c;

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    assign pair_hit[p] = (pwm_level[2*p]   == act_high[2*p]) &&
                         (pwm_level[2*p+1] == act_high[2*p+1]);
  end

  assign set_c = en_q && (|pair_hit);
  assign clr_c = reg_wr && !reg_wdata[FLAG_BIT] && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      locked_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      if (set_c)      flag_q <= 1'b1;
      else if (clr_c) flag_q <= 1'b0;

      if (reg_wr)                armed_q <= 1'b0;
      else if (reg_rd && flag_q) armed_q <= 1'b1;

      if (reg_wr) begin
        ie_q <= reg_wdata[IE_BIT];
        if (!locked_q) begin
          en_q     <= reg_wdata[EN_BIT];
          locked_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[FLAG_BIT] = flag_q;
    reg_rdata[EN_BIT]   = en_q;
    reg_rdata[IE_BIT]   = ie_q;
  end

  assign short_flag  = flag_q;
  assign irq         = flag_q && ie_q;
  assign out_disable = flag_q;
endmodule

// File: rtl/cmp_short_detector_chk.sv
module cmp_short_detector_chk #(
  parameter int NPAIRS = 3,
  parameter int RW     = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*NPAIRS-1:0] pwm_level,
  input logic [2*NPAIRS-1:0] act_high,
  input logic                reg_wr,
  input logic [RW-1:0]       reg_wdata,
  input logic [RW-1:0]       reg_rdata,
  input logic                short_flag,
  input logic                irq,
  input logic                out_disable
);
  logic any_hit;
  logic wrote_q;

  always_comb begin
    any_hit = 1'b0;
    for (int p = 0; p < NPAIRS; p++)
      if (pwm_level[2*p] == act_high[2*p] && pwm_level[2*p+1] == act_high[2*p+1])
        any_hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      wrote_q <= 1'b0;
    else if (reg_wr) wrote_q <= 1'b1;

  a_r2_set_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_flag) |-> $past(any_hit && reg_rdata[9]));

  a_r3_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[9] && !short_flag) |=> !short_flag);

  a_r5_clear_needs_write0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(short_flag) |-> $past(reg_wr && !reg_wdata[RW-1]));

  a_r7_enable_locked: assert property (@(posedge clk) disable iff (!rst_n)
    wrote_q |=> $stable(reg_rdata[9]));

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (reg_rdata[RW-1] && reg_rdata[8]));

  a_r9_disable_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_disable == short_flag);

  a_r10_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~(16'h8300)) == '0);
endmodule

bind cmp_short_detector cmp_short_detector_chk #(.NPAIRS(NPAIRS), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_level(pwm_level), .act_high(act_high),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .short_flag(short_flag), .irq(irq), .out_disable(out_disable)
);

// File: tb/sim_cmp_short_detector.sv
`timescale 1ns/1ps
module sim_cmp_short_detector;
  logic clk = 0, rst_n = 0;
  logic [5:0] pwm_level = 6'b010101, act_high = 6'b111111;
  logic reg_rd = 0, reg_wr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic short_flag, irq, out_disable;

  int total = 0, bad = 0;
  bit m_flag, m_en, m_ie, m_locked, m_armed;
  string tag = "R1";
  bit finished = 0;

  always #2 clk = ~clk;

  cmp_short_detector u0 (.clk(clk), .rst_n(rst_n), .pwm_level(pwm_level),
    .act_high(act_high), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .short_flag(short_flag), .irq(irq), .out_disable(out_disable));

  task automatic check(string t, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  function automatic bit model_hit();
    for (int p = 0; p < 3; p++)
      if (pwm_level[2*p] == act_high[2*p] && pwm_level[2*p+1] == act_high[2*p+1]) return 1;
    return 0;
  endfunction

  task automatic compare_all();
    check({tag, " R10 rdata"}, reg_rdata, {m_flag, 5'b0, m_en, m_ie, 8'b0});
    check({tag, " flag"}, {15'b0, short_flag}, {15'b0, m_flag});
    check({tag, " R8 irq"}, {15'b0, irq}, {15'b0, m_flag & m_ie});
    check({tag, " R9 out_disable"}, {15'b0, out_disable}, {15'b0, m_flag});
  endtask

  task automatic step(bit rd, bit wr, logic [15:0] wd, logic [5:0] lv);
    bit set, clr, fl, ar;
    reg_rd = rd; reg_wr = wr; reg_wdata = wd; pwm_level = lv;
    fl = m_flag; ar = m_armed;
    set = m_en && model_hit();
    clr = wr && !wd[15] && ar;
    @(posedge clk);
    #0.1;
    m_flag = set ? 1'b1 : (clr ? 1'b0 : fl);
    m_armed = wr ? 1'b0 : ((rd && fl) ? 1'b1 : ar);
    if (wr) begin
      m_ie = wd[8];
      if (!m_locked) begin m_en = wd[9]; m_locked = 1; end
    end
    @(negedge clk);
    reg_rd = 0; reg_wr = 0;
    compare_all();
  endtask

  localparam logic [5:0] IDLE = 6'b010101;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1"; compare_all();
    step(0, 0, 0, IDLE);
    // R3: enable still 0 from reset, overlaps must not set the flag
    tag = "R3";
    step(0, 0, 0, 6'b000011);
    step(0, 0, 0, 6'b111111);
    check("R3 no set while disabled", {15'b0, short_flag}, 16'h0);
    // R7: first write enables comparison; later writes cannot turn it off
    tag = "R7";
    step(0, 1, 16'h0200, IDLE);
    step(0, 1, 16'h0000, IDLE);
    check("R7 enable held", {15'b0, reg_rdata[9]}, 16'h1);
    step(0, 1, 16'hFCFF, IDLE);
    check("R10 spare bits zero", reg_rdata & 16'h7CFF, 16'h0);
    // R2: complementary patterns never trip
    tag = "R2";
    step(0, 0, 0, 6'b101010);
    step(0, 0, 0, 6'b010101);
    check("R2 complementary safe", {15'b0, short_flag}, 16'h0);
    for (int p = 0; p < 3; p++) begin
      step(0, 0, 0, IDLE | (6'b11 << (2*p)));
      check("R2 pair overlap sets", {15'b0, short_flag}, 16'h1);
      tag = "R4";
      step(0, 0, 0, IDLE);
      step(0, 0, 0, IDLE);
      check("R4 sticky", {15'b0, short_flag}, 16'h1);
      tag = "R5";
      step(1, 0, 0, IDLE);
      step(0, 1, 16'h0000, IDLE);
      check("R5 read-then-clear", {15'b0, short_flag}, 16'h0);
      tag = "R2";
    end
    // R2: mixed polarity, pair1 active low
    act_high = 6'b110011;
    step(0, 0, 0, 6'b001100 ^ 6'b000100);
    check("R2 one leg active low only", {15'b0, short_flag}, 16'h0);
    step(0, 0, 0, 6'b000000);
    check("R2 active-low overlap sets", {15'b0, short_flag}, 16'h1);
    act_high = 6'b111111;
    // R5: write 0 without read leaves flag
    tag = "R5";
    step(0, 1, 16'h0000, IDLE);
    check("R5 no read no clear", {15'b0, short_flag}, 16'h1);
    step(1, 0, 0, IDLE);
    step(0, 1, 16'h8000, IDLE);
    tag = "R6";
    check("R6 write 1 no effect", {15'b0, short_flag}, 16'h1);
    step(0, 1, 16'h0000, IDLE);
    check("R5 read consumed by write", {15'b0, short_flag}, 16'h1);
    // R6: set wins over clear in same cycle
    step(1, 0, 0, IDLE);
    step(0, 1, 16'h0000, 6'b110101);
    check("R6 set beats clear", {15'b0, short_flag}, 16'h1);
    // R8: interrupt enable
    tag = "R8";
    step(0, 1, 16'h0100, IDLE);
    check("R8 irq high", {15'b0, irq}, 16'h1);
    step(1, 0, 0, IDLE);
    step(0, 1, 16'h0100, IDLE);
    check("R8 irq drops with flag", {15'b0, irq}, 16'h0);
    check("R9 disable drops", {15'b0, out_disable}, 16'h0);
    step(0, 1, 16'h0000, IDLE);
    step(0, 0, 0, 6'b010111);
    check("R8 irq gated off", {15'b0, irq}, 16'h0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule